// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Controller

This block is the digital control core of a two-channel digital-to-analog converter. A host writes 16-bit command words over a three-wire serial link (active-low chip select, serial clock, data in). The three most significant bits of each word choose an action. The remaining 13 bits carry a code or, when the action field is zero, an extended sub-command. Each channel holds a staging (input) register and a live (DAC) register. This lets the host stage new codes quietly and then switch both channels at the same moment. The block also keeps a shutdown flag per channel, guarded by a hardware lockout pin, and a user-driven output pin. A serial data output echoes the shift register so that several devices can be chained.

The serial lines are asynchronous to the system clock. They pass through a synchroniser and an edge detector. A word executes when chip select returns high, and only if at least 16 serial clocks arrived. An active-low clear zeroes all four code registers at once and is released in step with the system clock.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After `rst`, both codes are zero, both shutdown flags are low, `user_out` is low, `dout` is low and the output launch edge is the falling one.
- R2: Op field (word bits 15:13) 001 loads the 13-bit data (bits 12:0) into staging register A. Op 101 does the same for staging register B. Neither changes a live code.
- R3: Op 010 loads staging A with the data and then copies both staging registers into both live registers, so code A equals the data. Op 110 does the same with staging B as the target.
- R4: Op 011 writes the data straight into both live registers and leaves both staging registers unchanged.
- R5: Op 100 copies both staging registers into their live registers. With op 000, sub-command (bits 12:10) 001 copies staging A only, and sub-command 101 copies staging B only.
- R6: Op 111 sets both shutdown flags. Op 000 with sub-command 110 sets flag A, and with sub-command 111 sets flag B. Every shutdown command is ignored while `pd_allow` is low.
- R7: Any write to a channel's live register clears that channel's shutdown flag. Staging contents survive a shutdown.
- R8: Op 000 with sub-command 010 drives `user_out` low, and with sub-command 011 drives it high.
- R9: A frame with fewer than 16 serial clocks has no effect on any output except `dout`. A frame with more than 16 clocks executes the last 16 bits received.
- R10: Op 000 with bits 12:9 = 1001 selects rising-edge launch; 1000 selects falling-edge launch. In falling mode `dout` takes the shift register MSB at each falling SCLK. In rising mode it takes the MSB that leaves the register at each rising SCLK.
- R11: A low `clr_n` zeroes all staging and live registers without waiting for a clock edge. It leaves the shutdown flags and `user_out` unchanged.
- R12: A command's results appear at the fourth rising `clk` edge after `cs_n` rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low clear of all code registers |
| sclk | input | 1 | Serial clock (asynchronous) |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| din | input | 1 | Serial data, MSB first, taken at rising SCLK |
| pd_allow | input | 1 | High permits shutdown commands |
| dout | output | 1 | Serial echo for chaining |
| user_out | output | 1 | Host-controlled output pin |
| code_a | output | 13 | Live code of channel A |
| code_b | output | 13 | Live code of channel B |
| sd_a | output | 1 | Channel A shut down |
| sd_b | output | 1 | Channel B shut down |

## Verification
A serial line change needs two synchroniser clocks and one edge-detect compare before it takes effect. A serial-clock edge therefore shifts data and moves `dout` at the third rising `clk` after it. A chip-select rise registers an execute strobe at the third edge and updates the codes, flags and `user_out` at the fourth. The bench changes every serial line on a falling `clk` edge and holds it for four cycles. It samples `dout` at the end of each half period and the command results six cycles after chip select rises. One directed frame samples right after the third and the fourth edges to pin down the exact latency. A clear is sampled one nanosecond after `clr_n` falls, to show that it does not wait for a clock.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int DATA_W = 13;
  localparam int OP_W   = 3;
  localparam int SUB_W  = 3;
  localparam int WORD_W = OP_W + DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_EXT      = 3'b000,
    OP_STAGE_A  = 3'b001,
    OP_STAGE_A_GO = 3'b010,
    OP_LIVE_BOTH = 3'b011,
    OP_GO_BOTH  = 3'b100,
    OP_STAGE_B  = 3'b101,
    OP_STAGE_B_GO = 3'b110,
    OP_SLEEP_BOTH = 3'b111
  } op_e;

  typedef enum logic [SUB_W-1:0] {
    SUB_NOP     = 3'b000,
    SUB_GO_A    = 3'b001,
    SUB_PIN_LO  = 3'b010,
    SUB_PIN_HI  = 3'b011,
    SUB_EDGE    = 3'b100,
    SUB_GO_B    = 3'b101,
    SUB_SLEEP_A = 3'b110,
    SUB_SLEEP_B = 3'b111
  } sub_e;
endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int           W      = 3,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
      prev <= IDLE;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl = stg[STAGES-1];
endmodule

// File: rtl/dac_shift_port.sv
module dac_shift_port #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              cs_rise,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              bit_in,
  input  logic              edge_mode,
  output logic [WORD_W-1:0] word,
  output logic              exec_en,
  output logic              dout
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      word    <= '0;
      cnt     <= '0;
      exec_en <= 1'b0;
      dout    <= 1'b0;
    end else begin
      exec_en <= cs_rise && (cnt == FULL);
      if (!cs_act) begin
        cnt <= '0;
      end else begin
        if (bit_rise) begin
          word <= {word[WORD_W-2:0], bit_in};
          if (cnt != FULL) cnt <= cnt + 1'b1;
          if (edge_mode) dout <= word[WORD_W-1];
        end
        if (bit_fall && !edge_mode) dout <= word[WORD_W-1];
      end
    end
  end
endmodule

// File: rtl/dac_cmd_exec.sv
module dac_cmd_exec
  import dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_hold,
  input  logic              exec_en,
  input  logic [WORD_W-1:0] word,
  input  logic              pd_allow,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              sd_a,
  output logic              sd_b,
  output logic              user_out,
  output logic              edge_mode
);
  logic [DATA_W-1:0] stage_a, stage_b;
  logic [DATA_W-1:0] n_stage_a, n_stage_b, n_code_a, n_code_b;
  logic              n_sd_a, n_sd_b, n_user, n_edge;
  logic [DATA_W-1:0] data;
  op_e               op;
  sub_e              sub;

  assign data = word[DATA_W-1:0];
  assign op   = op_e'(word[WORD_W-1 -: OP_W]);
  assign sub  = sub_e'(word[DATA_W-1 -: SUB_W]);

  always_comb begin
    n_stage_a = stage_a;
    n_stage_b = stage_b;
    n_code_a  = code_a;
    n_code_b  = code_b;
    n_sd_a    = sd_a;
    n_sd_b    = sd_b;
    n_user    = user_out;
    n_edge    = edge_mode;
    if (exec_en) begin
      case (op)
        OP_STAGE_A: n_stage_a = data;
        OP_STAGE_B: n_stage_b = data;
        OP_STAGE_A_GO: begin
          n_stage_a = data;
          n_code_a  = data;
          n_code_b  = stage_b;
          n_sd_a    = 1'b0;
          n_sd_b    = 1'b0;
        end
        OP_STAGE_B_GO: begin
          n_stage_b = data;
          n_code_b  = data;
          n_code_a  = stage_a;
          n_sd_a    = 1'b0;
          n_sd_b    = 1'b0;
        end
        OP_LIVE_BOTH: begin
          n_code_a = data;
          n_code_b = data;
          n_sd_a   = 1'b0;
          n_sd_b   = 1'b0;
        end
        OP_GO_BOTH: begin
          n_code_a = stage_a;
          n_code_b = stage_b;
          n_sd_a   = 1'b0;
          n_sd_b   = 1'b0;
        end
        OP_SLEEP_BOTH: begin
          if (pd_allow) begin
            n_sd_a = 1'b1;
            n_sd_b = 1'b1;
          end
        end
        default: begin
          case (sub)
            SUB_GO_A: begin
              n_code_a = stage_a;
              n_sd_a   = 1'b0;
            end
            SUB_GO_B: begin
              n_code_b = stage_b;
              n_sd_b   = 1'b0;
            end
            SUB_SLEEP_A: if (pd_allow) n_sd_a = 1'b1;
            SUB_SLEEP_B: if (pd_allow) n_sd_b = 1'b1;
            SUB_PIN_LO:  n_user = 1'b0;
            SUB_PIN_HI:  n_user = 1'b1;
            SUB_EDGE:    n_edge = word[DATA_W-SUB_W-1];
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or posedge clr_hold) begin
    if (clr_hold) begin
      stage_a <= '0;
      stage_b <= '0;
      code_a  <= '0;
      code_b  <= '0;
    end else if (rst) begin
      stage_a <= '0;
      stage_b <= '0;
      code_a  <= '0;
      code_b  <= '0;
    end else begin
      stage_a <= n_stage_a;
      stage_b <= n_stage_b;
      code_a  <= n_code_a;
      code_b  <= n_code_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_a      <= 1'b0;
      sd_b      <= 1'b0;
      user_out  <= 1'b0;
      edge_mode <= 1'b0;
    end else begin
      sd_a      <= n_sd_a;
      sd_b      <= n_sd_b;
      user_out  <= n_user;
      edge_mode <= n_edge;
    end
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              pd_allow,
  output logic              dout,
  output logic              user_out,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              sd_a,
  output logic              sd_b
);
  // line order in the synchroniser: {din, cs_n, sclk}
  localparam logic [2:0] LINE_IDLE = 3'b010;

  logic [2:0]        line_lvl, line_prev;
  logic              sclk_rise, sclk_fall, cs_rise, cs_act;
  logic              unused_din_prev;
  logic [WORD_W-1:0] word;
  logic              exec_en, edge_mode;
  logic [1:0]        clr_q;
  logic              clr_hold;

  dac_in_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .IDLE   (LINE_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d    ({din, cs_n, sclk}),
    .lvl  (line_lvl),
    .prev (line_prev)
  );

  assign sclk_rise       = line_lvl[0] & ~line_prev[0];
  assign sclk_fall       = ~line_lvl[0] & line_prev[0];
  assign cs_rise         = line_lvl[1] & ~line_prev[1];
  assign cs_act          = ~line_lvl[1];
  assign unused_din_prev = line_prev[2];

  dac_shift_port #(.WORD_W(WORD_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .cs_rise   (cs_rise),
    .bit_rise  (sclk_rise),
    .bit_fall  (sclk_fall),
    .bit_in    (line_lvl[2]),
    .edge_mode (edge_mode),
    .word      (word),
    .exec_en   (exec_en),
    .dout      (dout)
  );

  // clear: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) clr_q <= 2'b11;
    else        clr_q <= {clr_q[0], 1'b0};
  end
  assign clr_hold = clr_q[1];

  dac_cmd_exec u_exec (
    .clk       (clk),
    .rst       (rst),
    .clr_hold  (clr_hold),
    .exec_en   (exec_en),
    .word      (word),
    .pd_allow  (pd_allow),
    .code_a    (code_a),
    .code_b    (code_b),
    .sd_a      (sd_a),
    .sd_b      (sd_b),
    .user_out  (user_out),
    .edge_mode (edge_mode)
  );
endmodule

// File: rtl/dac_ctrl_checker.sv
module dac_ctrl_checker
  import dac_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              clr_n,
  input logic              pd_allow,
  input logic              exec_en,
  input logic              user_out,
  input logic [DATA_W-1:0] code_a,
  input logic [DATA_W-1:0] code_b,
  input logic              sd_a,
  input logic              sd_b
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!clr_n)
    rst |=> (code_a == '0 && code_b == '0 && !sd_a && !sd_b && !user_out));

  assert_sleep_a_lockout_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_a) |-> $past(pd_allow));

  assert_sleep_b_lockout_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_b) |-> $past(pd_allow));

  assert_wake_on_write_a_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(code_a) && code_a != '0) |-> !sd_a);

  assert_wake_on_write_b_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(code_b) && code_b != '0) |-> !sd_b);

  assert_pin_after_frame_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(user_out) |-> $past(exec_en));

  assert_code_after_frame_R12: assert property (@(posedge clk) disable iff (rst)
    (!$stable(code_a) && code_a != '0) |-> $past(exec_en));

  assert_clear_zeroes_R11: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (code_a == '0 && code_b == '0));
endmodule

bind dual_dac_ctrl dac_ctrl_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_n    (clr_n),
  .pd_allow (pd_allow),
  .exec_en  (exec_en),
  .user_out (user_out),
  .code_a   (code_a),
  .code_b   (code_b),
  .sd_a     (sd_a),
  .sd_b     (sd_b)
);

// File: tb/dual_dac_ctrl_test.sv
`timescale 1ns/1ps
module dual_dac_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic din = 1'b0;
  logic pd_allow = 1'b0;
  logic dout, user_out, sd_a, sd_b;
  logic [12:0] code_a, code_b;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench model state
  logic [12:0] m_in_a = '0, m_in_b = '0, m_dac_a = '0, m_dac_b = '0;
  logic m_sd_a = 0, m_sd_b = 0, m_uo = 0, m_mode = 0;
  logic [15:0] m_shift = '0;
  logic exp_dout = 0;

  always #10 clk = ~clk;

  dual_dac_ctrl uut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .pd_allow(pd_allow), .dout(dout), .user_out(user_out),
    .code_a(code_a), .code_b(code_b), .sd_a(sd_a), .sd_b(sd_b)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string req);
    cmp(req, "code_a", int'(code_a), int'(m_dac_a));
    cmp(req, "code_b", int'(code_b), int'(m_dac_b));
    cmp(req, "sd_a", int'(sd_a), int'(m_sd_a));
    cmp(req, "sd_b", int'(sd_b), int'(m_sd_b));
    cmp(req, "user_out", int'(user_out), int'(m_uo));
  endtask

  // expected effect of one executed word (R2..R8, R10)
  task automatic m_exec(input logic [15:0] w);
    logic [12:0] d;
    d = w[12:0];
    case (w[15:13])
      3'b001: m_in_a = d;
      3'b101: m_in_b = d;
      3'b010: begin m_in_a = d; m_dac_a = d; m_dac_b = m_in_b; m_sd_a = 0; m_sd_b = 0; end
      3'b110: begin m_in_b = d; m_dac_b = d; m_dac_a = m_in_a; m_sd_a = 0; m_sd_b = 0; end
      3'b011: begin m_dac_a = d; m_dac_b = d; m_sd_a = 0; m_sd_b = 0; end
      3'b100: begin m_dac_a = m_in_a; m_dac_b = m_in_b; m_sd_a = 0; m_sd_b = 0; end
      3'b111: if (pd_allow) begin m_sd_a = 1; m_sd_b = 1; end
      default: begin
        case (w[12:10])
          3'b001: begin m_dac_a = m_in_a; m_sd_a = 0; end
          3'b101: begin m_dac_b = m_in_b; m_sd_b = 0; end
          3'b110: if (pd_allow) m_sd_a = 1;
          3'b111: if (pd_allow) m_sd_b = 1;
          3'b010: m_uo = 0;
          3'b011: m_uo = 1;
          3'b100: m_mode = w[9];
          default: ;
        endcase
      end
    endcase
  endtask

  // one frame of nbits serial clocks; the last 16 bits carry w
  task automatic send(input logic [15:0] w, input int nbits, input string req, input bit lat);
    logic [31:0] stream;
    logic [12:0] old_a;
    stream = {16'($urandom), w};
    old_a = m_dac_a;
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      din = stream[nbits-1-i];
      repeat (4) @(negedge clk);
      sclk = 1;
      repeat (4) @(negedge clk);
      if (m_mode) exp_dout = m_shift[15];
      m_shift = {m_shift[14:0], din};
      cmp("R10", "dout after rise", int'(dout), int'(exp_dout));
      sclk = 0;
      repeat (4) @(negedge clk);
      if (!m_mode) exp_dout = m_shift[15];
      cmp("R10", "dout after fall", int'(dout), int'(exp_dout));
    end
    cs_n = 1;
    if (nbits >= 16) m_exec(stream[15:0]);
    if (lat) begin
      repeat (3) @(negedge clk);
      cmp("R12", "code_a before 4th edge", int'(code_a), int'(old_a));
      @(negedge clk);
      cmp("R12", "code_a at 4th edge", int'(code_a), int'(m_dac_a));
      repeat (2) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
    end
    check_outs(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_outs("R1");
    cmp("R1", "dout", int'(dout), 0);

    // R2: staging only
    send(16'h2123, 16, "R2", 0);
    send(16'hBABC, 16, "R2", 0);
    // R5: individual and joint transfer
    send(16'h0400, 16, "R5", 0);
    send(16'h1400, 16, "R5", 0);
    send(16'h2777, 16, "R5", 0);
    send(16'h8000, 16, "R5", 0);
    // R3 with latency probe (R12)
    send(16'h4FFF, 16, "R3", 1);
    send(16'hDFFF, 16, "R3", 0);
    // R4
    send(16'h6555, 16, "R4", 0);
    // R6 lockout then allowed
    pd_allow = 0;
    send(16'hE000, 16, "R6", 0);
    send(16'h1800, 16, "R6", 0);
    pd_allow = 1;
    send(16'hE000, 16, "R6", 0);
    // R7: wake A only, staging kept
    send(16'h0400, 16, "R7", 0);
    send(16'h1400, 16, "R7", 0);
    send(16'h1C00, 16, "R6", 0);
    send(16'h1800, 16, "R6", 0);
    send(16'h6001, 16, "R7", 0);
    // R8
    send(16'h0C00, 16, "R8", 0);
    send(16'h0800, 16, "R8", 0);
    // R9 short and long frames
    send(16'h6AAA, 12, "R9", 0);
    send(16'h6123, 20, "R9", 0);
    // R10 rising launch, then back to falling
    send(16'h1200, 16, "R10", 0);
    send(16'h2F0F, 16, "R10", 0);
    send(16'h1000, 16, "R10", 0);
    send(16'h2F0F, 16, "R10", 0);
    // R11 asynchronous clear
    send(16'hC0F0, 16, "R11", 0);
    pd_allow = 1;
    send(16'h1800, 16, "R11", 0);
    #3 clr_n = 0;
    #1;
    m_in_a = '0; m_in_b = '0; m_dac_a = '0; m_dac_b = '0;
    check_outs("R11");
    repeat (3) @(negedge clk);
    clr_n = 1;
    repeat (4) @(negedge clk);
    check_outs("R11");
    send(16'h8000, 16, "R11", 0);

    // constrained random frames
    for (int k = 0; k < 250; k++) begin
      logic [15:0] w;
      int sel;
      int nb;
      w = 16'($urandom);
      if ($urandom % 3 == 0) w[15:13] = 3'b000;
      pd_allow = ($urandom % 4) != 0;
      sel = $urandom % 8;
      nb = (sel == 0) ? 12 : (sel == 1) ? 19 : 16;
      send(w, nb, nb < 16 ? "R9" : "R5", 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule